// File: doc/BRIEF.md
# Per-Destination Interrupt Priority Selector

This block sits between an interrupt source unit and one processor. One copy is placed per destination processor. The source unit forwards a request carrying a source index, a priority and a vector. The block compares the priority with a task-priority threshold that software holds in the block. An accepted request sets a bit in a raised bitmap and records the priority and vector of that source. The block then sends an activity pulse back to the source unit.

A balanced comparison tree scans the raised bitmap. Its result is registered and published as the current selection, which is the highest-priority raised source. The processor interrupt line rises only when a newly accepted request outranks the selection on record. When the processor acknowledges, the block returns the vector of the selected source and drops that source from the raised set. If nothing is raised, the acknowledge returns a programmable spurious vector instead. A small two-entry register port gives access to the task priority and the spurious vector.

Top module: `irq_select_queue`

## Requirements
- R1: After reset the task priority reads 0x0F, the spurious vector reads 0xFF, the interrupt line is low, no selection is valid, and no activity, miss or acknowledge pulse is present.
- R2: A request whose priority is less than or equal to the task priority is dropped. It produces no activity pulse and no miss pulse, and it leaves the raised set unchanged.
- R3: A request whose priority is strictly above the task priority, for a source whose raised bit is clear, is accepted. One cycle later `act_valid` pulses with `act_src` equal to the source index. The source's bit, priority and vector are recorded.
- R4: A request that passes the threshold while its source's bit is already raised is a missed interrupt. One cycle later `miss_pulse` pulses, no activity pulse is given, and the recorded priority of that source is unchanged.
- R5: The selection is the raised source with the highest priority. Among equal priorities the lowest index wins. The selection appears on `sel_valid`/`sel_src`/`sel_prio` one cycle after the raised set changes.
- R6: With an empty raised set, `sel_valid` is low and both `sel_src` and `sel_prio` read all ones, which stands for "-1".
- R7: The interrupt line is set one cycle after an accepted request in two cases: no selection is on record, or the request's priority is strictly above the recorded selection priority. Any other accepted request leaves the line unchanged.
- R8: The interrupt line clears when the raised set is empty, or when its best priority is no longer above the task priority. The line drops one cycle after the scan sees that condition, and it is not raised again until a later request beats the selection.
- R9: When `ack_req` is high for a cycle with a valid selection, `ack_valid` pulses one cycle later. `ack_vec` carries the recorded vector of the selected source, and that source's raised bit is cleared.
- R10: An acknowledge with no valid selection returns the spurious vector on `ack_vec` and changes nothing else.
- R11: On the register port, address 0 is the task priority (low PRIO_W bits of the data) and address 1 is the spurious vector. Writes take effect on the next clock edge. `reg_rdata` reflects the addressed register combinationally, with the task priority zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Forwarded request strobe |
| req_src | input | IDX_W | Source index of the request |
| req_prio | input | PRIO_W | Priority of the request |
| req_vec | input | VEC_W | Vector of the request |
| act_valid | output | 1 | Activity-set pulse to the source unit |
| act_src | output | IDX_W | Source whose activity bit is to be set |
| miss_pulse | output | 1 | Duplicate-raise (missed interrupt) pulse |
| cpu_irq | output | 1 | Interrupt line to the processor |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_vec | output | VEC_W | Returned vector (spurious when empty) |
| sel_valid | output | 1 | A raised source is selected |
| sel_src | output | IDX_W | Selected source, all ones when none |
| sel_prio | output | PRIO_W | Selected priority, all ones when none |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: task priority, 1: spurious vector |
| reg_wdata | input | VEC_W | Register write data |
| reg_rdata | output | VEC_W | Register read data |

## Verification
The bench uses the default parameters: 64 sources, 5-bit priority and 8-bit vector. With these values the top index 63 and the all-ones "-1" encoding collide by value, so `sel_valid` must be the only thing that tells them apart. The full 5-bit priority range also lets the reset threshold of 15 block mid-range priorities. Sources are spread across the tree so that ties between distant leaves (indices 4 and 10) exercise the comparison at several tree levels, not just between sibling leaves.

// File: rtl/isq_pkg.sv
// Package: default sizes and register-port addresses shared by the
// priority selector and its checker.
package isq_pkg;
    localparam int ISQ_NUM_SRC  = 64;   // raised-set size, power of two
    localparam int ISQ_PRIO_W   = 5;    // request priority width
    localparam int ISQ_VEC_W    = 8;    // vector width, >= priority width
    localparam int ISQ_TP_RST   = 15;   // task priority after reset
    localparam int ISQ_SPUR_RST = 255;  // spurious vector after reset

    typedef enum logic {
        ISQ_REG_TASKPRI = 1'b0,
        ISQ_REG_SPUR    = 1'b1
    } isq_reg_e;
endpackage

// File: rtl/isq_entry_store.sv
// Raised-set storage. Holds one raised bit per source plus the priority and
// vector captured when that source was accepted.
// Assumes the caller never sets and clears the same index in one cycle
// unless set is meant to win (set is applied last).
module isq_entry_store #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 5,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [PRIO_W-1:0] set_prio,
    input  logic [VEC_W-1:0]  set_vec,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [NUM_SRC-1:0] raised_o,
    output logic [PRIO_W-1:0] prio_o [NUM_SRC],
    output logic [VEC_W-1:0]  vec_o  [NUM_SRC]
);
    logic [NUM_SRC-1:0] raised_q;
    logic [PRIO_W-1:0]  prio_q [NUM_SRC];
    logic [VEC_W-1:0]   vec_q  [NUM_SRC];

    // Raised bitmap: cleared on acknowledge, set on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= '0;
        end else begin
            if (clr_en) raised_q[clr_idx] <= 1'b0;
            if (set_en) raised_q[set_idx] <= 1'b1;
        end
    end

    // Payload capture: priority and vector of an accepted source.
    always_ff @(posedge clk) begin
        if (set_en) begin
            prio_q[set_idx] <= set_prio;
            vec_q[set_idx]  <= set_vec;
        end
    end

    assign raised_o = raised_q;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_out
            assign prio_o[g] = prio_q[g];
            assign vec_o[g]  = vec_q[g];
        end
    endgenerate
endmodule

// File: rtl/isq_prio_tree.sv
// Combinational max-priority tree over the raised set. Nodes are kept in heap
// order: node n has children 2n+1 (lower indices) and 2n+2 (higher indices).
// A right child replaces the left only with a strictly greater priority, so
// the lowest index wins ties. Assumes NUM_SRC is a power of two.
module isq_prio_tree #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 5,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int NODES  = 2 * NUM_SRC - 1
) (
    input  logic [NUM_SRC-1:0] raised_i,
    input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
    output logic               best_vld,
    output logic [IDX_W-1:0]   best_idx,
    output logic [PRIO_W-1:0]  best_prio
);
    logic              node_v [NODES];
    logic [PRIO_W-1:0] node_p [NODES];
    logic [IDX_W-1:0]  node_i [NODES];

    generate
        for (genvar l = 0; l < NUM_SRC; l++) begin : g_leaf
            assign node_v[NUM_SRC-1+l] = raised_i[l];
            assign node_p[NUM_SRC-1+l] = prio_i[l];
            assign node_i[NUM_SRC-1+l] = IDX_W'(l);
        end
        for (genvar n = 0; n < NUM_SRC - 1; n++) begin : g_node
            logic take_r;
            // Pick the right subtree only when it strictly outranks the left.
            assign take_r = node_v[2*n+2] &&
                            (!node_v[2*n+1] || (node_p[2*n+2] > node_p[2*n+1]));
            assign node_v[n] = node_v[2*n+1] || node_v[2*n+2];
            assign node_p[n] = take_r ? node_p[2*n+2] : node_p[2*n+1];
            assign node_i[n] = take_r ? node_i[2*n+2] : node_i[2*n+1];
        end
    endgenerate

    assign best_vld  = node_v[0];
    assign best_idx  = node_i[0];
    assign best_prio = node_p[0];
endmodule

// File: rtl/isq_ctrl_regs.sv
// Register port: task-priority threshold and spurious vector.
// Writes land on the next edge; reads are combinational.
module isq_ctrl_regs #(
    parameter int PRIO_W   = 5,
    parameter int VEC_W    = 8,
    parameter int TP_RST   = 15,
    parameter int SPUR_RST = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [VEC_W-1:0]  reg_rdata,
    output logic [PRIO_W-1:0] task_prio,
    output logic [VEC_W-1:0]  spur_vec
);
    import isq_pkg::*;

    logic [PRIO_W-1:0] tp_q;
    logic [VEC_W-1:0]  spur_q;

    // Register writes with synchronous reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q   <= PRIO_W'(TP_RST);
            spur_q <= VEC_W'(SPUR_RST);
        end else if (reg_we) begin
            if (reg_addr == ISQ_REG_TASKPRI) tp_q   <= reg_wdata[PRIO_W-1:0];
            else                             spur_q <= reg_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        if (reg_addr == ISQ_REG_TASKPRI) reg_rdata = VEC_W'(tp_q);
        else                             reg_rdata = spur_q;
    end

    assign task_prio = tp_q;
    assign spur_vec  = spur_q;
endmodule

// File: rtl/irq_select_queue.sv
// Per-destination interrupt priority selector. Filters forwarded requests
// against the task priority, records accepted ones in a raised set, selects
// the best raised source through a registered tree scan, drives the processor
// interrupt line and answers acknowledges with the selected vector.
// Assumes: NUM_SRC is a power of two, VEC_W >= PRIO_W, and acknowledges are
// spaced so the registered selection is current (one cycle after a change).
module irq_select_queue
    import isq_pkg::*;
#(
    parameter int NUM_SRC  = ISQ_NUM_SRC,
    parameter int PRIO_W   = ISQ_PRIO_W,
    parameter int VEC_W    = ISQ_VEC_W,
    parameter int TP_RST   = ISQ_TP_RST,
    parameter int SPUR_RST = ISQ_SPUR_RST,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [VEC_W-1:0]  req_vec,
    output logic              act_valid,
    output logic [IDX_W-1:0]  act_src,
    output logic              miss_pulse,
    output logic              cpu_irq,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vec,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_src,
    output logic [PRIO_W-1:0] sel_prio,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [VEC_W-1:0]  reg_rdata
);
    logic [PRIO_W-1:0]  task_prio_q;
    logic [VEC_W-1:0]   spur_q;
    logic [NUM_SRC-1:0] raised;
    logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
    logic [VEC_W-1:0]   vec_arr  [NUM_SRC];
    logic               scan_vld;
    logic [IDX_W-1:0]   scan_idx;
    logic [PRIO_W-1:0]  scan_prio;
    logic               sel_vld_q;
    logic [IDX_W-1:0]   sel_idx_q;
    logic [PRIO_W-1:0]  sel_prio_q;
    logic               irq_q;
    logic               act_q;
    logic [IDX_W-1:0]   act_src_q;
    logic               miss_q;
    logic               ack_q;
    logic [VEC_W-1:0]   ack_vec_q;
    logic               pass_w;
    logic               accept_w;
    logic               miss_w;
    logic               beat_w;
    logic               quiet_w;
    logic               ack_hit_w;

    isq_ctrl_regs #(
        .PRIO_W(PRIO_W), .VEC_W(VEC_W), .TP_RST(TP_RST), .SPUR_RST(SPUR_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .task_prio(task_prio_q), .spur_vec(spur_q)
    );

    isq_entry_store #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .set_en(accept_w), .set_idx(req_src), .set_prio(req_prio), .set_vec(req_vec),
        .clr_en(ack_hit_w), .clr_idx(sel_idx_q),
        .raised_o(raised), .prio_o(prio_arr), .vec_o(vec_arr)
    );

    isq_prio_tree #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) u_tree (
        .raised_i(raised), .prio_i(prio_arr),
        .best_vld(scan_vld), .best_idx(scan_idx), .best_prio(scan_prio)
    );

    // Request filter: threshold test, then duplicate test on the raised bit.
    always_comb begin
        pass_w   = req_valid && (req_prio > task_prio_q);
        accept_w = pass_w && !raised[req_src];
        miss_w   = pass_w &&  raised[req_src];
        beat_w   = accept_w && (!sel_vld_q || (req_prio > sel_prio_q));
        quiet_w  = !scan_vld || (scan_prio <= task_prio_q);
        ack_hit_w = ack_req && sel_vld_q;
    end

    // Registered selection; all ones stands for "no request".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_vld_q  <= 1'b0;
            sel_idx_q  <= '1;
            sel_prio_q <= '1;
        end else begin
            sel_vld_q  <= scan_vld;
            sel_idx_q  <= scan_vld ? scan_idx  : '1;
            sel_prio_q <= scan_vld ? scan_prio : '1;
        end
    end

    // Interrupt line: set on a beating accept, cleared when nothing qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (beat_w)  irq_q <= 1'b1;
        else if (quiet_w) irq_q <= 1'b0;
    end

    // Activity and miss pulses back to the source unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            act_src_q <= '0;
            miss_q    <= 1'b0;
        end else begin
            act_q     <= accept_w;
            act_src_q <= accept_w ? req_src : act_src_q;
            miss_q    <= miss_w;
        end
    end

    // Acknowledge response: selected vector, or spurious when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            ack_vec_q <= '0;
        end else begin
            ack_q <= ack_req;
            if (ack_req) ack_vec_q <= sel_vld_q ? vec_arr[sel_idx_q] : spur_q;
        end
    end

    assign act_valid  = act_q;
    assign act_src    = act_src_q;
    assign miss_pulse = miss_q;
    assign cpu_irq    = irq_q;
    assign ack_valid  = ack_q;
    assign ack_vec    = ack_vec_q;
    assign sel_valid  = sel_vld_q;
    assign sel_src    = sel_idx_q;
    assign sel_prio   = sel_prio_q;
endmodule

// Protocol checker for the priority selector, bound to every instance.
module isq_checker #(
    parameter int IDX_W  = 6,
    parameter int PRIO_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PRIO_W-1:0] req_prio,
    input logic [PRIO_W-1:0] task_prio,
    input logic              act_valid,
    input logic              miss_pulse,
    input logic              cpu_irq,
    input logic              ack_req,
    input logic              ack_valid,
    input logic              sel_valid,
    input logic [IDX_W-1:0]  sel_src,
    input logic [PRIO_W-1:0] sel_prio
);
    assert_above_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ($past(req_prio) > $past(task_prio)));
    assert_act_or_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_valid && miss_pulse));
    assert_empty_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> ((&sel_src) && (&sel_prio)));
    assert_sel_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_prio != '0));
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> act_valid);
    assert_ack_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);
endmodule

bind irq_select_queue isq_checker #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_isq_chk (
    .clk(clk), .rst_n(rst_n), .req_prio(req_prio), .task_prio(task_prio_q),
    .act_valid(act_valid), .miss_pulse(miss_pulse), .cpu_irq(cpu_irq),
    .ack_req(ack_req), .ack_valid(ack_valid), .sel_valid(sel_valid),
    .sel_src(sel_src), .sel_prio(sel_prio)
);

// File: tb/sim_irq_select_queue.sv
`timescale 1ns/1ps
module sim_irq_select_queue;
    localparam int N = 64, PW = 5, VW = 8, IW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0; logic [IW-1:0] req_src = 0; logic [PW-1:0] req_prio = 0;
    logic [VW-1:0] req_vec = 0;
    logic act_valid, miss_pulse, cpu_irq, ack_valid, sel_valid;
    logic [IW-1:0] act_src, sel_src; logic [PW-1:0] sel_prio;
    logic [VW-1:0] ack_vec, reg_rdata;
    logic ack_req = 0, reg_we = 0, reg_addr = 0; logic [VW-1:0] reg_wdata = 0;

    irq_select_queue u0 (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit m_raised [N]; int m_prio [N]; int m_vec [N];
    int m_tp = 15, m_spur = 255; bit m_irq = 0;
    int exp_q [$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int best_idx();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (m_raised[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
        return b;
    endfunction

    task automatic quiet_rule();
        int b = best_idx();
        if (b < 0 || m_prio[b] <= m_tp) m_irq = 0;
    endtask

    task automatic chk_sel(string req);
        int b = best_idx();
        chk({req, " sel_valid"}, sel_valid, b >= 0);
        chk({req, " sel_src"}, sel_src, b >= 0 ? b : 63);
        chk({req, " sel_prio"}, sel_prio, b >= 0 ? m_prio[b] : 31);
    endtask

    // Driver: one request, then check the pulses and the new selection.
    task automatic send(int s, int p, int v, string req);
        bit pass = p > m_tp; bit acc = pass && !m_raised[s];
        int b = best_idx();
        @(negedge clk); req_valid = 1; req_src = IW'(s); req_prio = PW'(p); req_vec = VW'(v);
        @(negedge clk); req_valid = 0;
        if (acc) begin
            if (b < 0 || p > m_prio[b]) m_irq = 1;
            m_raised[s] = 1; m_prio[s] = p; m_vec[s] = v;
        end
        chk({req, " act_valid"}, act_valid, acc);
        if (acc) chk({req, " act_src"}, act_src, s);
        chk({req, " miss_pulse"}, miss_pulse, pass && !acc);
        chk({req, " cpu_irq"}, cpu_irq, m_irq);
        @(negedge clk);
        chk_sel(req);
    endtask

    // Driver: acknowledge; expected vector goes to the scoreboard queue.
    task automatic ack(string req);
        int b = best_idx();
        @(negedge clk); ack_req = 1;
        exp_q.push_back(b >= 0 ? m_vec[b] : m_spur);
        if (b >= 0) m_raised[b] = 0;
        @(negedge clk); ack_req = 0;
        @(negedge clk);
        quiet_rule();
        chk({req, " cpu_irq after ack"}, cpu_irq, m_irq);
        chk_sel(req);
    endtask

    task automatic wr(int a, int d, string req);
        @(negedge clk); reg_we = 1; reg_addr = a[0]; reg_wdata = VW'(d);
        @(negedge clk); reg_we = 0;
        if (a == 0) m_tp = d & 31; else m_spur = d;
        chk({req, " readback"}, reg_rdata, a == 0 ? (d & 31) : d);
        @(negedge clk);
        quiet_rule();
        chk({req, " cpu_irq"}, cpu_irq, m_irq);
    endtask

    // Monitor: pop and compare each acknowledge response.
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) chk("R9 unexpected ack", 1, 0);
            else chk("R9/R10 ack_vec", ack_vec, exp_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cpu_irq", cpu_irq, 0);
        chk("R1 act_valid", act_valid, 0);
        chk("R1 ack_valid", ack_valid, 0);
        chk_sel("R1/R6 reset");
        reg_addr = 0; #1 chk("R1 task prio", reg_rdata, 15);
        reg_addr = 1; #1 chk("R1 spurious", reg_rdata, 255);
        // R2 at-threshold and below dropped
        send(3, 15, 7, "R2 equal");
        send(5, 2, 7, "R2 below");
        // R11 threshold write, R3/R7 first accept
        wr(0, 2, "R11 task prio");
        send(10, 5, 8'hA0, "R3 R7 first");
        // R4 duplicate
        send(10, 9, 8'h11, "R4 dup");
        // R5 tie: lower index 4 wins
        send(4, 5, 8'h44, "R5 tie");
        send(20, 7, 8'h20, "R5 higher");
        // R8 threshold raised to best -> line clears
        wr(0, 7, "R8 raise tp");
        wr(0, 2, "R8 lower tp no reraise");
        // R7 non-beating accept leaves line low, beating sets it
        send(30, 6, 8'h30, "R7 no beat");
        send(31, 8, 8'h31, "R7 beat");
        // R11 spurious vector write
        wr(1, 8'h3C, "R11 spurious");
        // R9 acknowledges in priority order: 31, 20, 30, 4, 10
        for (int k = 0; k < 5; k++) ack("R9 ack");
        // R10 empty acknowledge returns spurious, R8 line low
        ack("R10 empty");
        chk("R8 empty cpu_irq", cpu_irq, 0);
        chk("R9 queue drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule